// File: doc/BRIEF.md
# Host Parameter Register Bank with Switchable Addressing

This block is the host-side slave of a video conversion chip. A narrow 8-bit host bus with an active-low select, active-low read and write strobes and a 4-bit address reaches a bank of sixteen 8-bit parameter and mode registers. The host strobes are asynchronous to the core clock. The block synchronises them, and a small state machine turns each write strobe into a single commit cycle. Reads are combinational, so the returned byte follows the address while the read strobe is held.

A strap input picks how the address is used. In direct mode the 4-bit address names the register. In indirect mode, location 0 is a 4-bit pointer and location 1 is a window onto the register the pointer names. A second strap picks one of two default vertical-position sets, which a synchronous reset loads. A third input decides whether the two filter enables seen by the core come from input pins or from a mode register. The host data bus is split into input, output and output-enable lines, and the pad ring joins them.

The write state machine has three states. IDLE moves to ARMED when the synchronised select and write strobe are both low. ARMED captures address and data on every cycle. From ARMED it moves to COMMIT when the write strobe has risen, or back to IDLE (an abort) when the select rises first. COMMIT applies the write and always returns to IDLE.

Top module: `hostreg_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every register returns to its default. Index 2 and all other registers clear to 0, and the pointer clears to 0. With `vpos_sel` high, the back porch is 45 and the active end is 530. With `vpos_sel` low, they are 35 and 514.
- R2: In direct mode (`addr_direct` = 1), a write to address A stores the byte in register A, and a read of address A returns it.
- R3: In indirect mode (`addr_direct` = 0), a write to location 0 loads the pointer from data bits 3:0. A read of location 0 returns the pointer with bits 7:4 zero. The pointer never advances on its own.
- R4: In indirect mode, a write to location 1 stores into the register that the pointer names, and a read of location 1 returns that register.
- R5: In indirect mode, writes to locations 2 to 15 change no register, and reads of those locations return 0.
- R6: A write takes effect only after the write strobe rises while the select is still low. A strobe with the select high, or a select that rises before the strobe, changes nothing. Registers and pointer change only in the commit cycle.
- R7: `host_rdata_oe` is high exactly while `host_cs_n` and `host_rd_n` are both low.
- R8: The back porch is held as a low byte at index 4 and a high byte at index 5. The active end is held at indexes 6 and 7 in the same way. Each value is 10 bits, and only bits 1:0 of a high byte are stored, so bits 7:2 read as 0. `vback_porch` and `vactive_end` show the assembled values.
- R9: With `filt_src_pins` high, `vfilt_en` follows `vfilt_pin` and `hfilt_en` follows `hfilt_pin`. With it low, they follow bits 0 and 1 of register index 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 4 | Host address |
| host_wdata | input | 8 | Host data into the block |
| host_rdata | output | 8 | Read data toward the pad |
| host_rdata_oe | output | 1 | Pad output enable for read data |
| addr_direct | input | 1 | 1 = direct addressing, 0 = pointer and window |
| vpos_sel | input | 1 | Selects the vertical default set |
| filt_src_pins | input | 1 | 1 = filter enables from pins |
| vfilt_pin | input | 1 | Vertical filter enable pin |
| hfilt_pin | input | 1 | Horizontal filter enable pin |
| vfilt_en | output | 1 | Vertical filter enable to the core |
| hfilt_en | output | 1 | Horizontal filter enable to the core |
| vback_porch | output | 10 | Vertical back porch value |
| vactive_end | output | 10 | Vertical active end value |

## Verification
In direct mode, all sixteen indexes are swept with a byte that is a different arithmetic function of the index in each pass. This separates address decode faults, and the hard-wired zeros in the high bytes, from storage faults. The indirect sweep walks the pointer over every value and repeats window reads. It then cross-checks the result through direct reads, which catches a wrong target, pointer auto-increment and stray writes to the unused locations. Separate strobe patterns cover a write with the select high and a select released before the strobe rises. All four filter pin and register combinations are tried under both source settings, and reset runs with both strap values.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;
    localparam int VPOS_W = 10;

    // register layout
    localparam int IDX_MODE  = 2;
    localparam int IDX_BP_L  = 4;
    localparam int IDX_BP_H  = 5;
    localparam int IDX_END_L = 6;
    localparam int IDX_END_H = 7;

    // indirect locations
    localparam int LOC_PTR = 0;
    localparam int LOC_WIN = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_COMMIT = 2'd2
    } wr_state_t;

endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
    parameter int         WIDTH   = 1,
    parameter logic [0:0] RST_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= {WIDTH{RST_BIT}};
            stage2 <= {WIDTH{RST_BIT}};
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/hostreg_wrfsm.sv
module hostreg_wrfsm
    import hostreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              wr_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output wr_state_t         state
);
    wr_state_t state_nx;
    logic      capture;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_n_s && !wr_n_s) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_n_s)      state_nx = ST_COMMIT;
                else if (cs_n_s) state_nx = ST_IDLE;
            end
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_IDLE:   capture = !cs_n_s && !wr_n_s;
            ST_ARMED:  capture = !wr_n_s;
            ST_COMMIT: commit  = 1'b1;
            default: begin
                capture = 1'b0;
                commit  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (capture) begin
            cap_addr <= addr_s;
            cap_data <= data_s;
        end
    end
endmodule

// File: rtl/hostreg_regfile.sv
module hostreg_regfile
    import hostreg_pkg::*;
#(
    parameter int BP_DFLT_A  = 45,
    parameter int END_DFLT_A = 530,
    parameter int BP_DFLT_B  = 35,
    parameter int END_DFLT_B = 514
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vpos_sel,
    input  logic              direct,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] mode_reg,
    output logic [VPOS_W-1:0] bp_val,
    output logic [VPOS_W-1:0] end_val
);
    localparam int HI_W = VPOS_W - DATA_W;
    localparam logic [VPOS_W-1:0] BP_A  = VPOS_W'(BP_DFLT_A);
    localparam logic [VPOS_W-1:0] END_A = VPOS_W'(END_DFLT_A);
    localparam logic [VPOS_W-1:0] BP_B  = VPOS_W'(BP_DFLT_B);
    localparam logic [VPOS_W-1:0] END_B = VPOS_W'(END_DFLT_B);
    localparam logic [DATA_W-1:0] HI_MASK = DATA_W'((1 << HI_W) - 1);

    logic [DATA_W-1:0] regs [NREG];

    function automatic logic [DATA_W-1:0] dflt_of(int idx, logic sel);
        logic [VPOS_W-1:0] bp;
        logic [VPOS_W-1:0] en;
        bp = sel ? BP_A : BP_B;
        en = sel ? END_A : END_B;
        case (idx)
            IDX_BP_L:  return bp[DATA_W-1:0];
            IDX_BP_H:  return DATA_W'(bp[VPOS_W-1:DATA_W]);
            IDX_END_L: return en[DATA_W-1:0];
            IDX_END_H: return DATA_W'(en[VPOS_W-1:DATA_W]);
            default:   return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] mask_of(int idx);
        if (idx == IDX_BP_H || idx == IDX_END_H) return HI_MASK;
        return '1;
    endfunction

    // pointer
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (commit && !direct && cap_addr == ADDR_W'(LOC_PTR))
            ptr <= cap_data[ADDR_W-1:0];
    end

    // storage
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = mask_of(i);
        logic hit;
        assign hit = commit &&
                     ((direct && cap_addr == ADDR_W'(i)) ||
                      (!direct && cap_addr == ADDR_W'(LOC_WIN) && ptr == ADDR_W'(i)));
        always_ff @(posedge clk) begin
            if (rst)      regs[i] <= dflt_of(i, vpos_sel);
            else if (hit) regs[i] <= cap_data & MASK;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (direct)
            rd_data = regs[rd_addr];
        else if (rd_addr == ADDR_W'(LOC_PTR))
            rd_data = DATA_W'(ptr);
        else if (rd_addr == ADDR_W'(LOC_WIN))
            rd_data = regs[ptr];
    end

    assign mode_reg = regs[IDX_MODE];
    assign bp_val   = {regs[IDX_BP_H][HI_W-1:0], regs[IDX_BP_L]};
    assign end_val  = {regs[IDX_END_H][HI_W-1:0], regs[IDX_END_L]};
endmodule

// File: rtl/hostreg_bank.sv
module hostreg_bank
    import hostreg_pkg::*;
#(
    parameter int BP_DFLT_A  = 45,
    parameter int END_DFLT_A = 530,
    parameter int BP_DFLT_B  = 35,
    parameter int END_DFLT_B = 514
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_oe,
    input  logic              addr_direct,
    input  logic              vpos_sel,
    input  logic              filt_src_pins,
    input  logic              vfilt_pin,
    input  logic              hfilt_pin,
    output logic              vfilt_en,
    output logic              hfilt_en,
    output logic [VPOS_W-1:0] vback_porch,
    output logic [VPOS_W-1:0] vactive_end
);
    logic [1:0]        strb_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] mode_reg;
    wr_state_t         fsm_state;

    hostreg_sync #(.WIDTH(2), .RST_BIT(1'b1)) u_sync_strb (
        .clk(clk), .rst(rst), .d({host_cs_n, host_wr_n}), .q(strb_s)
    );

    hostreg_sync #(.WIDTH(ADDR_W + DATA_W), .RST_BIT(1'b0)) u_sync_bus (
        .clk(clk), .rst(rst), .d({host_addr, host_wdata}), .q({addr_s, data_s})
    );

    hostreg_wrfsm u_fsm (
        .clk(clk), .rst(rst),
        .cs_n_s(strb_s[1]), .wr_n_s(strb_s[0]),
        .addr_s(addr_s), .data_s(data_s),
        .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data),
        .state(fsm_state)
    );

    hostreg_regfile #(
        .BP_DFLT_A(BP_DFLT_A), .END_DFLT_A(END_DFLT_A),
        .BP_DFLT_B(BP_DFLT_B), .END_DFLT_B(END_DFLT_B)
    ) u_regs (
        .clk(clk), .rst(rst), .vpos_sel(vpos_sel), .direct(addr_direct),
        .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data),
        .rd_addr(host_addr), .rd_data(host_rdata), .ptr(ptr),
        .mode_reg(mode_reg), .bp_val(vback_porch), .end_val(vactive_end)
    );

    assign host_rdata_oe = !host_cs_n && !host_rd_n;
    assign vfilt_en = filt_src_pins ? vfilt_pin : mode_reg[0];
    assign hfilt_en = filt_src_pins ? hfilt_pin : mode_reg[1];
endmodule

// File: rtl/hostreg_bank_chk.sv
module hostreg_bank_chk
    import hostreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_cs_n,
    input logic              host_rd_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_rdata_oe,
    input logic              addr_direct,
    input logic              filt_src_pins,
    input logic              vfilt_pin,
    input logic              hfilt_pin,
    input logic              vfilt_en,
    input logic              hfilt_en,
    input logic [VPOS_W-1:0] vback_porch,
    input logic [VPOS_W-1:0] vactive_end,
    input logic              commit,
    input logic [ADDR_W-1:0] ptr,
    input wr_state_t         fsm_state
);
    // R7: enable only with select and read strobe low
    always @(posedge clk) begin
        if (!rst)
            assert_oe_gated_R7: assert (!host_rdata_oe || (!host_cs_n && !host_rd_n));
    end

    // R6: commit is only ever entered from ARMED
    assert_commit_from_armed_R6: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(fsm_state) == ST_ARMED);

    // R6: vertical values hold unless a commit happened
    assert_vpos_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(vback_porch) && $stable(vactive_end)));

    // R3: pointer does not move on its own
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(ptr));

    // R8: high bytes read with bits 7:2 zero
    assert_hibyte_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (addr_direct && (host_addr == ADDR_W'(IDX_BP_H) || host_addr == ADDR_W'(IDX_END_H)))
        |-> host_rdata[DATA_W-1:2] == '0);

    // R9: pin source drives enables
    assert_filt_pins_R9: assert property (@(posedge clk) disable iff (rst)
        filt_src_pins |-> (vfilt_en == vfilt_pin && hfilt_en == hfilt_pin));
endmodule

bind hostreg_bank hostreg_bank_chk u_chk (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_addr(host_addr), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .addr_direct(addr_direct), .filt_src_pins(filt_src_pins),
    .vfilt_pin(vfilt_pin), .hfilt_pin(hfilt_pin),
    .vfilt_en(vfilt_en), .hfilt_en(hfilt_en),
    .vback_porch(vback_porch), .vactive_end(vactive_end),
    .commit(commit), .ptr(ptr), .fsm_state(fsm_state)
);

// File: tb/hostreg_bank_test.sv
module hostreg_bank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       direct = 1'b1, vsel = 1'b1, fsrc = 1'b0, vpin = 1'b0, hpin = 1'b0;
    logic       ven, hen;
    logic [9:0] vbp, vend;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [16];
    logic [3:0] mptr;

    always #5 clk = ~clk;

    hostreg_bank uut (
        .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .host_rdata_oe(rdata_oe),
        .addr_direct(direct), .vpos_sel(vsel), .filt_src_pins(fsrc),
        .vfilt_pin(vpin), .hfilt_pin(hpin), .vfilt_en(ven), .hfilt_en(hen),
        .vback_porch(vbp), .vactive_end(vend)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(int i, logic [7:0] v);
        return (i == 5 || i == 7) ? (v & 8'h03) : v;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[4] = vsel ? 8'd45 : 8'd35;
        model[5] = 8'd0;
        model[6] = vsel ? 8'h12 : 8'h02;
        model[7] = 8'h02;
        mptr = '0;
        @(negedge clk);
    endtask

    // mode: 0 normal, 1 select held high, 2 select released before strobe
    task automatic hwrite(logic [3:0] a, logic [7:0] d, int mode);
        @(negedge clk);
        addr = a; wdata = d; cs_n = (mode == 1);
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        if (mode == 2) begin
            cs_n = 1'b1;
            repeat (4) @(negedge clk);
        end
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic hread(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        d = rdata;
        check("R7 oe during read", int'(rdata_oe), 1);
        rd_n = 1'b1; cs_n = 1'b1;
        #1;
        check("R7 oe after read", int'(rdata_oe), 0);
    endtask

    task automatic model_write(logic [3:0] a, logic [7:0] d);
        if (direct) model[a] = msk(a, d);
        else if (a == 0) mptr = d[3:0];
        else if (a == 1) model[mptr] = msk(mptr, d);
    endtask

    task automatic verify_direct(string req);
        logic [7:0] v;
        logic       sv;
        sv = direct; direct = 1'b1;
        for (int i = 0; i < 16; i++) begin
            hread(4'(i), v);
            check(req, int'(v), int'(model[i]));
        end
        check({req, " bp"}, int'(vbp), int'({model[5][1:0], model[4]}));
        check({req, " end"}, int'(vend), int'({model[7][1:0], model[6]}));
        direct = sv;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R1 reset, both strap values
        vsel = 1'b1; do_reset();
        check("R1 bp strap high", int'(vbp), 45);
        check("R1 end strap high", int'(vend), 530);
        check("R7 oe idle", int'(rdata_oe), 0);
        verify_direct("R1 defaults strap high");
        vsel = 1'b0; do_reset();
        check("R1 bp strap low", int'(vbp), 35);
        check("R1 end strap low", int'(vend), 514);
        verify_direct("R1 defaults strap low");

        // R7: read strobe alone with select high
        @(negedge clk); rd_n = 1'b0; cs_n = 1'b1; #1;
        check("R7 oe select high", int'(rdata_oe), 0);
        rd_n = 1'b1;

        // R2 R8 direct sweeps with two patterns
        direct = 1'b1;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 16; i++) begin
                v = 8'((i * 37 + k * 101 + 90) & 8'hFF);
                hwrite(4'(i), v, 0);
                model_write(4'(i), v);
            end
            verify_direct("R2 R8 direct sweep");
        end

        // R6 ignored strobes
        hwrite(4'd4, 8'hC3, 1);
        verify_direct("R6 select high ignored");
        hwrite(4'd6, 8'h3C, 2);
        verify_direct("R6 aborted write ignored");

        // R9 filter source combinations
        for (int m = 0; m < 4; m++) begin
            hwrite(4'd2, 8'(m), 0);
            model_write(4'd2, 8'(m));
            for (int p = 0; p < 4; p++) begin
                vpin = p[0]; hpin = p[1];
                fsrc = 1'b1; #1;
                check("R9 pins v", int'(ven), p & 1);
                check("R9 pins h", int'(hen), (p >> 1) & 1);
                fsrc = 1'b0; #1;
                check("R9 reg v", int'(ven), m & 1);
                check("R9 reg h", int'(hen), (m >> 1) & 1);
            end
        end

        // R3 R4 indirect sweep
        direct = 1'b0;
        for (int p = 0; p < 16; p++) begin
            hwrite(4'd0, 8'(8'hA0 | p), 0);
            model_write(4'd0, 8'(8'hA0 | p));
            hread(4'd0, v);
            check("R3 pointer readback", int'(v), p);
            v = 8'((p * 53 + 7) & 8'hFF);
            hwrite(4'd1, v, 0);
            model_write(4'd1, v);
            hread(4'd1, v);
            check("R4 window read", int'(v), int'(model[p]));
            hread(4'd1, v);
            check("R4 window repeat read", int'(v), int'(model[p]));
            hread(4'd0, v);
            check("R3 no auto increment", int'(v), p);
        end
        verify_direct("R4 indirect cross check");

        // R5 unused indirect locations
        for (int a = 2; a < 16; a++) begin
            hwrite(4'(a), 8'hFF, 0);
            hread(4'(a), v);
            check("R5 unused read zero", int'(v), 0);
        end
        hread(4'd0, v);
        check("R5 pointer untouched", int'(v), int'(mptr));
        verify_direct("R5 unused write ignored");

        // R1 reset after writes
        vsel = 1'b1; do_reset();
        direct = 1'b0;
        hread(4'd0, v);
        check("R1 pointer cleared", int'(v), 0);
        verify_direct("R1 reset after writes");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule